// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block turns a single host command into the timed strobe sequence that one on-chip flash program or erase operation needs. A host loads nine 8-bit timing registers (a shared prescaler divisor and one count per phase), then issues a word program, a page erase or a whole-module erase. The sequencer raises the matching operation enable, waits a setup interval, raises the non-volatile-store strobe, optionally waits a transition interval, drives the high-voltage pulse, drops the enable while holding the store strobe, waits a recovery interval and finally reports completion.

Every interval is counted in prescaled ticks of (DIV+1) system clocks, with fixed multipliers of 1, 8 or 4096 depending on the phase. A per-row accumulator totals the system-clock cycles of programming pulse each row has received since it was last erased and refuses a program that would push a row beyond its limit; rows below `PROG_ROWS` belong to program memory and use the larger limit, the remaining rows belong to data memory.

Top module: `flash_pe_seq`

## Requirements
- R1: With T = DIV+1 system clocks, after an accepted command the setup phase (operation enable high, store strobe low) lasts (START+1)·T cycles, starting the cycle after the accepting edge.
- R2: After setup the store strobe rises while the enable stays high; the strobe-on-without-pulse interval lasts 1 + (TRAN+1)·T cycles for a program and exactly 1 cycle for an erase.
- R3: A program pulse (`hv_pulse` high with `prog_en`) lasts 8·(PROG+1)·T cycles.
- R4: A page erase pulse lasts 4096·(PER+1)·T cycles on `erase_en`; a module erase pulse lasts 4096·(MER+1)·T cycles on `mass_en`; at most one enable is high at any time.
- R5: After the pulse the enable falls while the store strobe stays high for (END+1)·T cycles, or 8·(MEND+1)·T cycles after a module erase.
- R6: A recovery interval of (RCV+1)·T cycles with `busy` high and all strobes low follows; then `done` is high for exactly one cycle with `busy` low and a new command is accepted.
- R7: Timing registers are written through `cfg_addr` with index 0 DIV, 1 START, 2 TRAN, 3 PROG, 4 PER, 5 MER, 6 END, 7 MEND, 8 RCV and read back combinationally on `cfg_rdata`; a write while `busy` is high leaves the register unchanged.
- R8: A command while `busy` is high, or a command with `cmd_op` = 3, is rejected: `cmd_err` is high for one cycle and the running operation is unaffected (opcodes: 0 program, 1 page erase, 2 module erase).
- R9: Each accepted program adds 8·(PROG+1)·(DIV+1) cycles to the addressed row's total; a program whose total would exceed the row limit (`HV_LIM_PMEM` for rows below `PROG_ROWS`, `HV_LIM_DMEM` otherwise) is refused with `hv_err` high for one cycle and no operation starts.
- R10: A page erase clears the addressed row's total; a module erase clears every row's total.
- R11: After reset all strobes, `busy`, `done`, `cmd_err`, `hv_err` are low and every timing register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 4 | Timing register index |
| cfg_wdata | input | REG_W | Timing register write data |
| cfg_rdata | output | REG_W | Timing register read data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code |
| cmd_row | input | $clog2(NROWS) | Target row |
| prog_en | output | 1 | Program enable |
| erase_en | output | 1 | Page erase enable |
| mass_en | output | 1 | Module erase enable |
| nvstr | output | 1 | Non-volatile-store strobe |
| hv_pulse | output | 1 | High-voltage pulse window |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle command rejection |
| hv_err | output | 1 | One-cycle cumulative-voltage refusal |

## Verification
The assertions assume the host changes timing registers only while the block is idle and never issues a command in the same cycle as a register write, since the accumulated pulse length is taken from the values present at acceptance. They also assume `cmd_row` is below `NROWS`. The stimulus keeps to this by writing registers in separate idle cycles before each command, and by confining the only writes attempted during an operation to the deliberate busy-time probes, which the design must discard.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_NVON, PH_TRAN, PH_PULSE, PH_HOLD, PH_RECOV
    } phase_e;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0, OP_PAGE = 2'd1, OP_MASS = 2'd2, OP_NONE = 2'd3
    } op_e;

    localparam int NREG   = 9;
    localparam int RI_DIV = 0;
    localparam int RI_STA = 1;
    localparam int RI_TRN = 2;
    localparam int RI_PRG = 3;
    localparam int RI_PER = 4;
    localparam int RI_MER = 5;
    localparam int RI_END = 6;
    localparam int RI_MND = 7;
    localparam int RI_RCV = 8;
endpackage

// File: rtl/flash_pe_presc.sv
module flash_pe_presc #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [REG_W-1:0] div,
    output logic             tick
);
    logic [REG_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        if (clr) begin
            pre_d = '0;
        end else if (pre_q >= div) begin
            pre_d = '0;
            tick  = 1'b1;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/flash_pe_hvtrk.sv
module flash_pe_hvtrk #(
    parameter int NROWS     = 8,
    parameter int PROG_ROWS = 4,
    parameter int ACC_W     = 32,
    parameter int LIM_PMEM  = 192000,
    parameter int LIM_DMEM  = 96000,
    localparam int ROW_W    = $clog2(NROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row,
    input  logic [ACC_W-1:0] len,
    input  logic             add_en,
    input  logic             clr_row,
    input  logic             clr_all,
    output logic             ok
);
    logic [ACC_W-1:0] acc_d [NROWS];
    logic [ACC_W-1:0] acc_q [NROWS];
    logic [ACC_W:0]   lim   [NROWS];

    for (genvar r = 0; r < NROWS; r++) begin : g_lim
        if (r < PROG_ROWS) begin : g_p
            assign lim[r] = (ACC_W+1)'(LIM_PMEM);
        end else begin : g_d
            assign lim[r] = (ACC_W+1)'(LIM_DMEM);
        end
    end

    always_comb begin
        ok = 1'b0;
        for (int r = 0; r < NROWS; r++) begin
            if (row == ROW_W'(r))
                ok = ({1'b0, acc_q[r]} + {1'b0, len}) <= lim[r];
        end
    end

    always_comb begin
        for (int r = 0; r < NROWS; r++) begin
            acc_d[r] = acc_q[r];
            if (clr_all)
                acc_d[r] = '0;
            else if (clr_row && row == ROW_W'(r))
                acc_d[r] = '0;
            else if (add_en && row == ROW_W'(r))
                acc_d[r] = acc_q[r] + len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NROWS; r++) acc_q[r] <= '0;
        end else begin
            for (int r = 0; r < NROWS; r++) acc_q[r] <= acc_d[r];
        end
    end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int NROWS       = 8,
    parameter int PROG_ROWS   = 4,
    parameter int ACC_W       = 32,
    parameter int HV_LIM_PMEM = 192000,
    parameter int HV_LIM_DMEM = 96000,
    localparam int ROW_W      = $clog2(NROWS),
    localparam int CNT_W      = REG_W + 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    output logic             prog_en,
    output logic             erase_en,
    output logic             mass_en,
    output logic             nvstr,
    output logic             hv_pulse,
    output logic             busy,
    output logic             done,
    output logic             cmd_err,
    output logic             hv_err
);
    typedef struct packed {
        phase_e                       ph;
        op_e                          op;
        logic [CNT_W-1:0]             cnt;
        logic                         done;
        logic                         cerr;
        logic                         herr;
        logic [NREG-1:0][REG_W-1:0]   cfg;
    } st_t;

    st_t st_d, st_q;
    logic             tick, hv_ok, hv_add, hv_clr_row, hv_clr_all, en_any;
    logic [CNT_W-1:0] plen;
    logic [ACC_W-1:0] pulse_cyc;
    logic [NREG*REG_W-1:0] cfg_all;

    assign cfg_all = st_q.cfg;

    flash_pe_presc #(.REG_W(REG_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (st_q.ph == PH_IDLE || st_q.ph == PH_NVON),
        .div  (st_q.cfg[RI_DIV]),
        .tick (tick)
    );

    assign pulse_cyc = ACC_W'((CNT_W'(st_q.cfg[RI_PRG]) + 1'b1) << 3)
                     * (ACC_W'(st_q.cfg[RI_DIV]) + 1'b1);

    flash_pe_hvtrk #(
        .NROWS(NROWS), .PROG_ROWS(PROG_ROWS), .ACC_W(ACC_W),
        .LIM_PMEM(HV_LIM_PMEM), .LIM_DMEM(HV_LIM_DMEM)
    ) u_hv (
        .clk    (clk),
        .rst_n  (rst_n),
        .row    (cmd_row),
        .len    (pulse_cyc),
        .add_en (hv_add),
        .clr_row(hv_clr_row),
        .clr_all(hv_clr_all),
        .ok     (hv_ok)
    );

    // phase length in prescaled ticks
    always_comb begin
        unique case (st_q.ph)
            PH_SETUP: plen = CNT_W'(st_q.cfg[RI_STA]) + 1'b1;
            PH_TRAN:  plen = CNT_W'(st_q.cfg[RI_TRN]) + 1'b1;
            PH_PULSE: begin
                if (st_q.op == OP_PROG)
                    plen = (CNT_W'(st_q.cfg[RI_PRG]) + 1'b1) << 3;
                else if (st_q.op == OP_MASS)
                    plen = (CNT_W'(st_q.cfg[RI_MER]) + 1'b1) << 12;
                else
                    plen = (CNT_W'(st_q.cfg[RI_PER]) + 1'b1) << 12;
            end
            PH_HOLD: begin
                if (st_q.op == OP_MASS)
                    plen = (CNT_W'(st_q.cfg[RI_MND]) + 1'b1) << 3;
                else
                    plen = CNT_W'(st_q.cfg[RI_END]) + 1'b1;
            end
            PH_RECOV: plen = CNT_W'(st_q.cfg[RI_RCV]) + 1'b1;
            default:  plen = CNT_W'(1);
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.cerr  = 1'b0;
        st_d.herr  = 1'b0;
        hv_add     = 1'b0;
        hv_clr_row = 1'b0;
        hv_clr_all = 1'b0;

        if (st_q.ph == PH_IDLE) begin
            if (cfg_we) begin
                for (int i = 0; i < NREG; i++)
                    if (cfg_addr == 4'(i)) st_d.cfg[i] = cfg_wdata;
            end
            if (cmd_valid) begin
                if (op_e'(cmd_op) == OP_NONE) begin
                    st_d.cerr = 1'b1;
                end else if (op_e'(cmd_op) == OP_PROG && !hv_ok) begin
                    st_d.herr = 1'b1;
                end else begin
                    st_d.ph    = PH_SETUP;
                    st_d.op    = op_e'(cmd_op);
                    st_d.cnt   = '0;
                    hv_add     = op_e'(cmd_op) == OP_PROG;
                    hv_clr_row = op_e'(cmd_op) == OP_PAGE;
                    hv_clr_all = op_e'(cmd_op) == OP_MASS;
                end
            end
        end else begin
            st_d.cerr = cmd_valid;
            if (st_q.ph == PH_NVON) begin
                st_d.ph  = (st_q.op == OP_PROG) ? PH_TRAN : PH_PULSE;
                st_d.cnt = '0;
            end else if (tick) begin
                if (st_q.cnt == plen - 1'b1) begin
                    st_d.cnt = '0;
                    unique case (st_q.ph)
                        PH_SETUP: st_d.ph = PH_NVON;
                        PH_TRAN:  st_d.ph = PH_PULSE;
                        PH_PULSE: st_d.ph = PH_HOLD;
                        PH_HOLD:  st_d.ph = PH_RECOV;
                        default: begin
                            st_d.ph   = PH_IDLE;
                            st_d.done = 1'b1;
                        end
                    endcase
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, op: OP_PROG, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (cfg_addr == 4'(i)) cfg_rdata = st_q.cfg[i];
    end

    assign en_any   = st_q.ph inside {PH_SETUP, PH_NVON, PH_TRAN, PH_PULSE};
    assign prog_en  = en_any && st_q.op == OP_PROG;
    assign erase_en = en_any && st_q.op == OP_PAGE;
    assign mass_en  = en_any && st_q.op == OP_MASS;
    assign nvstr    = st_q.ph inside {PH_NVON, PH_TRAN, PH_PULSE, PH_HOLD};
    assign hv_pulse = st_q.ph == PH_PULSE;
    assign busy     = st_q.ph != PH_IDLE;
    assign done     = st_q.done;
    assign cmd_err  = st_q.cerr;
    assign hv_err   = st_q.herr;
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
    parameter int CFG_W = 72
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_en,
    input logic             erase_en,
    input logic             mass_en,
    input logic             nvstr,
    input logic             hv_pulse,
    input logic             busy,
    input logic             done,
    input logic             hv_err,
    input logic [CFG_W-1:0] cfg_flat
);
    logic any_en;
    assign any_en = prog_en | erase_en | mass_en;

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_en, erase_en, mass_en})); // R4
    AST_STORE_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nvstr) |-> any_en && $past(any_en)); // R2
    AST_PULSE_INSIDE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        hv_pulse |-> nvstr && any_en); // R3
    AST_HOLD_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_en) |-> nvstr); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !nvstr && !any_en); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_flat)); // R7
    AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hv_err |-> !busy); // R9
endmodule

bind flash_pe_seq flash_pe_seq_chk #(.CFG_W(flash_pe_pkg::NREG * REG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_en (prog_en),
    .erase_en(erase_en),
    .mass_en (mass_en),
    .nvstr   (nvstr),
    .hv_pulse(hv_pulse),
    .busy    (busy),
    .done    (done),
    .hv_err  (hv_err),
    .cfg_flat(cfg_all)
);

// File: tb/sim_flash_pe_seq.sv
module sim_flash_pe_seq;
    localparam int CLK_P = 10;
    localparam int LIM_P = 600;
    localparam int LIM_D = 300;
    localparam int NR    = 8;
    localparam int PR    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [2:0] cmd_row = '0;
    logic prog_en, erase_en, mass_en, nvstr, hv_pulse, busy, done, cmd_err, hv_err;

    int n_chk = 0;
    int n_bad = 0;
    int sh [9];
    int acc [NR];

    always #(CLK_P/2) clk = ~clk;

    flash_pe_seq #(
        .REG_W(8), .NROWS(NR), .PROG_ROWS(PR), .ACC_W(32),
        .HV_LIM_PMEM(LIM_P), .HV_LIM_DMEM(LIM_D)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_row(cmd_row), .prog_en(prog_en), .erase_en(erase_en),
        .mass_en(mass_en), .nvstr(nvstr), .hv_pulse(hv_pulse), .busy(busy),
        .done(done), .cmd_err(cmd_err), .hv_err(hv_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim_of(input int row);
        return (row < PR) ? LIM_P : LIM_D;
    endfunction

    function automatic int pcyc();
        return 8 * (sh[3] + 1) * (sh[0] + 1);
    endfunction

    task automatic wr(input int a, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        sh[a] = v;
    endtask

    task automatic run_op(input int op, input int row, input bit poke);
        int t, e_set, e_nv, e_pul, e_hold, e_rec;
        int c_set, c_nv, c_pul, c_hold, c_rec, c_wrong, n;
        bit refuse;
        t      = sh[0] + 1;
        e_set  = (sh[1] + 1) * t;
        e_nv   = (op == 0) ? 1 + (sh[2] + 1) * t : 1;
        e_pul  = (op == 0) ? 8 * (sh[3] + 1) * t
               : (op == 1) ? 4096 * (sh[4] + 1) * t : 4096 * (sh[5] + 1) * t;
        e_hold = (op == 2) ? 8 * (sh[7] + 1) * t : (sh[6] + 1) * t;
        e_rec  = (sh[8] + 1) * t;
        refuse = (op == 0) && (acc[row] + pcyc() > lim_of(row));
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_row = 3'(row);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (refuse) begin
            chk(hv_err && !busy, "R9 refuse", {hv_err, busy}, 2);
            return;
        end
        chk(!hv_err && busy, "R9 accept", {hv_err, busy}, 1);
        if (op == 0) acc[row] += pcyc();
        else if (op == 1) acc[row] = 0;
        else for (int r = 0; r < NR; r++) acc[r] = 0;
        c_set = 0; c_nv = 0; c_pul = 0; c_hold = 0; c_rec = 0; c_wrong = 0; n = 0;
        while (!done && n < 60000) begin
            logic en;
            en = prog_en | erase_en | mass_en;
            if (en && ((op == 0 && !prog_en) || (op == 1 && !erase_en) || (op == 2 && !mass_en)))
                c_wrong++;
            if (en && !nvstr) c_set++;
            else if (en && nvstr && !hv_pulse) c_nv++;
            else if (hv_pulse) c_pul++;
            else if (!en && nvstr) c_hold++;
            else if (busy) c_rec++;
            if (poke && n == 3) begin
                chk(cmd_err == 1'b1, "R8 busy reject", cmd_err, 1);
                cmd_valid = 1'b0; cfg_we = 1'b0;
            end
            if (poke && n == 2) begin
                cmd_valid = 1'b1; cmd_op = 2'd0;
                cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 8'(sh[8] ^ 8'hff);
            end
            n++;
            @(negedge clk);
        end
        chk(done, "R6 done seen", done, 1);
        chk(c_set == e_set, "R1 setup", c_set, e_set);
        chk(c_nv == e_nv, "R2 store setup", c_nv, e_nv);
        chk(c_pul == e_pul, (op == 0) ? "R3 program pulse" : "R4 erase pulse", c_pul, e_pul);
        chk(c_wrong == 0, "R4 enable select", c_wrong, 0);
        chk(c_hold == e_hold, "R5 hold", c_hold, e_hold);
        chk(c_rec == e_rec, "R6 recovery", c_rec, e_rec);
        chk(!busy, "R6 idle at done", busy, 0);
        @(negedge clk);
        chk(!done, "R6 done single", done, 1'b0);
        if (poke) begin
            cfg_addr = 4'd8;
            #1;
            chk(int'(cfg_rdata) == sh[8], "R7 busy write ignored", cfg_rdata, sh[8]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 9; i++) sh[i] = 0;
        for (int r = 0; r < NR; r++) acc[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({prog_en, erase_en, mass_en, nvstr, hv_pulse, busy, done, cmd_err, hv_err} == 0,
            "R11 outputs", {prog_en, erase_en, mass_en, nvstr, busy}, 0);
        for (int i = 0; i < 9; i++) begin
            cfg_addr = 4'(i); #1;
            chk(cfg_rdata == 0, "R11 register zero", cfg_rdata, 0);
        end
        // R7 readback
        for (int i = 0; i < 9; i++) wr(i, (i * 7 + 3) & 8'h07);
        for (int i = 0; i < 9; i++) begin
            cfg_addr = 4'(i); #1;
            chk(int'(cfg_rdata) == sh[i], "R7 readback", cfg_rdata, sh[i]);
        end
        // R8 reserved opcode
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk); cmd_valid = 1'b0;
        chk(cmd_err && !busy, "R8 reserved op", {cmd_err, busy}, 2);
        // R1..R3, R8 directed program with busy probes
        wr(0, 1); wr(3, 3);
        run_op(0, 5, 1'b1);
        // R9 fill data row to refusal, R10 page erase clears it
        for (int k = 0; k < 4; k++) run_op(0, 5, 1'b0);
        chk(acc[5] + pcyc() > LIM_D, "R9 limit reached", acc[5], LIM_D);
        run_op(0, 5, 1'b0);
        wr(0, 0); wr(4, 0);
        run_op(1, 5, 1'b0);
        wr(0, 1);
        run_op(0, 5, 1'b0);
        // R10 module erase clears all rows
        for (int k = 0; k < 4; k++) run_op(0, 1, 1'b0);
        wr(0, 0); wr(5, 0); wr(7, 2);
        run_op(2, 0, 1'b0);
        wr(0, 3); wr(3, 7);
        run_op(0, 1, 1'b0);
        // R4 page erase with larger count
        wr(0, 0); wr(4, 1);
        run_op(1, 2, 1'b0);
        // random mix
        for (int k = 0; k < 40; k++) begin
            int op;
            op = (($urandom % 8) == 0) ? 1 + int'($urandom % 2) : 0;
            wr(0, (op != 0) ? int'($urandom % 2) : int'($urandom % 4));
            for (int i = 1; i < 4; i++) wr(i, $urandom % 8);
            wr(4, 0); wr(5, 0);
            for (int i = 6; i < 9; i++) wr(i, $urandom % 8);
            run_op(op, int'($urandom % NR), k % 5 == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule